// File: doc/BRIEF.md
# Endpoint-Zero Control Stage Handler

This block is the device-side control logic for endpoint 0 of a USB function. It answers the status stage of control transfers. It also keeps a count of received bytes that the CPU can read, and it raises a buffer-empty interrupt. Decoded token events arrive from the serial interface engine as single-cycle pulses. The CPU sets up a direction bit, a completion bit and a 2-bit response code through one control register. The CPU also reads and writes an EP0 FIFO data port, which is modelled here as byte counters only.

The completion bit holds the status stage off. While it is 0, every status-stage token is answered with NAK. When the firmware sets it, the next status-stage token gets the normal answer: a zero-length data packet for a control write, or ACK of a zero-length packet for a control read. The hardware clears the completion bit on every SETUP token, so a new transfer always starts in the held-off state.

Top module: `ep0_ctl_stage`

## Requirements
- R1: After reset: hs_o is 0, rdy_o is 0, len_o is 0, irq_o is 0, and the completion bit, the direction bit and the response code all read 0.
- R2: A control write has direction bit = 0, and its status token is IN. If the completion bit is 1 and the response code is 01, that IN token gives the ZLP decision (hs_o = 4'b0100) in the next cycle.
- R3: A control read has direction bit = 1, and its status token is OUT. If the completion bit is 1 and the response code is 01, an OUT token with zlp_i = 1 gives ACK (4'b0001) in the next cycle. The same OUT token with zlp_i = 0 gives NAK (4'b0010).
- R4: A status-stage token gives NAK (4'b0010) when the completion bit is 0 or when the response code is 00.
- R5: A response code of 1x makes every IN or OUT token, in either stage, give STALL (4'b1000).
- R6: A SETUP token clears the completion bit. A register write in the same cycle does not keep the bit set.
- R7: A data-stage token (IN for a control read, OUT for a control write) with a response code other than 1x gives no decision: hs_o stays 0.
- R8: Each rx_byte_i pulse adds one to len_o, which stops at 511. Each FIFO read that is allowed subtracts one, and len_o stops at 0. If a byte arrives and an allowed read happens in the same cycle, len_o does not change.
- R9: rdy_o goes to 1 on rx_byte_i and back to 0 on rx_end_i. While rdy_o is 1, FIFO reads and writes have no effect.
- R10: A write with bit 14 set (buffer clear) discards the pending transmit bytes. If transmit bytes were pending, the write also sets irq_o. irq_o stays set until a write with bit 15 set (acknowledge). A set and an acknowledge in the same write leave irq_o at 1.
- R11: hs_o is registered and at most one-hot. It is 0 in any cycle that does not follow an IN or OUT token.
- R12: A control write loads the completion bit from bit 10, the direction bit from bit 9 and the response code from bits 13:12. The read word holds len in bits 8:0, direction in 9, completion in 10, rdy in 11, response code in 13:12 and irq in 15.

Hand-shake encoding on hs_o: bit 0 ACK, bit 1 NAK, bit 2 ZLP, bit 3 STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_tok_i | input | 1 | SETUP token event pulse |
| in_tok_i | input | 1 | IN token event pulse |
| out_tok_i | input | 1 | OUT token event pulse |
| zlp_i | input | 1 | The OUT data packet was zero length |
| rx_byte_i | input | 1 | The serial engine stored one received byte |
| rx_end_i | input | 1 | The serial engine finished the received packet |
| fifo_rd_i | input | 1 | The CPU reads the EP0 FIFO data port |
| fifo_wr_i | input | 1 | The CPU writes the EP0 FIFO data port |
| reg_wr_i | input | 1 | The CPU writes the control register |
| reg_wdata_i | input | 16 | Write data for the control register |
| reg_rdata_o | output | 16 | Read view of the control register |
| hs_o | output | 4 | One-hot handshake decision pulse |
| rdy_o | output | 1 | Buffer busy on the serial side |
| len_o | output | 9 | Received byte count |
| irq_o | output | 1 | Sticky buffer-empty interrupt |

## Verification
The assertions assume three things about the inputs. At most one token pulse is high in a cycle. zlp_i only matters together with out_tok_i. A buffer-clear write never happens in the same cycle as a FIFO write. The directed tests and the randomized phase draw a single token kind per cycle and raise zlp only alongside OUT. They also keep FIFO writes and clear writes apart. Byte arrivals and reads are still allowed to collide, so the balanced-count rule gets exercised.

// File: rtl/ep0_cs_pkg.sv
package ep0_cs_pkg;
  localparam int HS_W     = 4;
  localparam int HS_ACK   = 0;
  localparam int HS_NAK   = 1;
  localparam int HS_ZLP   = 2;
  localparam int HS_STALL = 3;

  localparam int DIR_BIT  = 9;
  localparam int CMPL_BIT = 10;
  localparam int RDY_BIT  = 11;
  localparam int RESP_LO  = 12;
  localparam int BCLR_BIT = 14;
  localparam int IACK_BIT = 15;

  localparam logic [1:0] RESP_NAK  = 2'b00;
  localparam logic [1:0] RESP_NORM = 2'b01;

  typedef struct packed {
    logic       cmpl;
    logic       dir;
    logic [1:0] resp;
  } ep0_cfg_t;
endpackage

// File: rtl/ep0_cs_cfg.sv
module ep0_cs_cfg
  import ep0_cs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  ep0_cfg_t wcfg_i,
  input  logic     setup_i,
  output ep0_cfg_t cfg_o
);
  ep0_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr_i) cfg_q <= wcfg_i;
      // SETUP wins over a same-cycle write
      if (setup_i) cfg_q.cmpl <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;

  // R6
  setup_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> !cfg_q.cmpl);
endmodule

// File: rtl/ep0_cs_cnt.sv
module ep0_cs_cnt #(
  parameter int LEN_W = 9,
  parameter int TX_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_byte_i,
  input  logic             rx_end_i,
  input  logic             fifo_rd_i,
  input  logic             fifo_wr_i,
  input  logic             bclr_i,
  output logic [LEN_W-1:0] len_o,
  output logic             busy_o,
  output logic             tx_pend_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [TX_W-1:0]  TX_MAX  = {TX_W{1'b1}};

  logic [LEN_W-1:0] len_q;
  logic [TX_W-1:0]  tx_q;
  logic             busy_q;
  logic             rd_ok, wr_ok;

  assign rd_ok = fifo_rd_i & ~busy_q;
  assign wr_ok = fifo_wr_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_q <= 1'b0;
    else if (rx_byte_i) busy_q <= 1'b1;
    else if (rx_end_i)  busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else begin
      unique case ({rx_byte_i, rd_ok})
        2'b10:   if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
        2'b01:   if (len_q != '0)      len_q <= len_q - 1'b1;
        default: len_q <= len_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tx_q <= '0;
    else if (bclr_i)                 tx_q <= '0;
    else if (wr_ok && tx_q != TX_MAX) tx_q <= tx_q + 1'b1;
  end

  assign len_o     = len_q;
  assign busy_o    = busy_q;
  assign tx_pend_o = (tx_q != '0);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rx_byte_i) |=> $stable(len_q));
  // R8
  len_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == LEN_MAX && rx_byte_i) |=> len_q == LEN_MAX);
  // R8
  len_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == '0 && !rx_byte_i) |=> len_q == '0);
endmodule

// File: rtl/ep0_cs_irq.sv
module ep0_cs_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclr_i,
  input  logic tx_pend_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  irq_q <= 1'b0;
    else if (bclr_i && tx_pend_i) irq_q <= 1'b1;
    else if (ack_i)               irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclr_i && tx_pend_i) |=> irq_q);
  // R10
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q);
endmodule

// File: rtl/ep0_cs_hs.sv
module ep0_cs_hs
  import ep0_cs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_tok_i,
  input  logic            out_tok_i,
  input  logic            zlp_i,
  input  ep0_cfg_t        cfg_i,
  output logic [HS_W-1:0] hs_o
);
  logic [HS_W-1:0] dec;
  logic [HS_W-1:0] hs_q;
  logic            any_tok, stat_tok;

  assign any_tok  = in_tok_i | out_tok_i;
  assign stat_tok = cfg_i.dir ? out_tok_i : in_tok_i;

  always_comb begin
    dec = '0;
    if (any_tok) begin
      if (cfg_i.resp[1]) begin
        dec[HS_STALL] = 1'b1;
      end else if (stat_tok) begin
        if (!cfg_i.cmpl || cfg_i.resp == RESP_NAK) dec[HS_NAK] = 1'b1;
        else if (!cfg_i.dir)                        dec[HS_ZLP] = 1'b1;
        else if (zlp_i)                             dec[HS_ACK] = 1'b1;
        else                                        dec[HS_NAK] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_q <= '0;
    else         hs_q <= dec;
  end

  assign hs_o = hs_q;

  // R11
  hs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hs_q));
  // R11
  hs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_tok |=> hs_q == '0);
  // R5
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_tok && cfg_i.resp[1]) |=> hs_q[HS_STALL]);
  // R4
  hold_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tok_i && !cfg_i.dir && !cfg_i.cmpl && !cfg_i.resp[1]) |=> hs_q[HS_NAK]);
  // R2
  wr_zlp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tok_i && !cfg_i.dir && cfg_i.cmpl && cfg_i.resp == RESP_NORM) |=> hs_q[HS_ZLP]);
endmodule

// File: rtl/ep0_ctl_stage.sv
module ep0_ctl_stage
  import ep0_cs_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int TX_W  = 9,
  parameter int DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_tok_i,
  input  logic             in_tok_i,
  input  logic             out_tok_i,
  input  logic             zlp_i,
  input  logic             rx_byte_i,
  input  logic             rx_end_i,
  input  logic             fifo_rd_i,
  input  logic             fifo_wr_i,
  input  logic             reg_wr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic [HS_W-1:0]  hs_o,
  output logic             rdy_o,
  output logic [LEN_W-1:0] len_o,
  output logic             irq_o
);
  ep0_cfg_t         wcfg, cfg;
  logic             bclr, iack, tx_pend, busy;
  logic [LEN_W-1:0] len;
  logic             unused_wd;

  assign wcfg.cmpl = reg_wdata_i[CMPL_BIT];
  assign wcfg.dir  = reg_wdata_i[DIR_BIT];
  assign wcfg.resp = reg_wdata_i[RESP_LO+1:RESP_LO];
  assign bclr      = reg_wr_i & reg_wdata_i[BCLR_BIT];
  assign iack      = reg_wr_i & reg_wdata_i[IACK_BIT];
  assign unused_wd = ^{reg_wdata_i[LEN_W-1:0], reg_wdata_i[RDY_BIT]};

  ep0_cs_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wcfg_i  (wcfg),
    .setup_i (setup_tok_i),
    .cfg_o   (cfg)
  );

  ep0_cs_cnt #(.LEN_W(LEN_W), .TX_W(TX_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_byte_i (rx_byte_i),
    .rx_end_i  (rx_end_i),
    .fifo_rd_i (fifo_rd_i),
    .fifo_wr_i (fifo_wr_i),
    .bclr_i    (bclr),
    .len_o     (len),
    .busy_o    (busy),
    .tx_pend_o (tx_pend)
  );

  ep0_cs_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bclr_i    (bclr),
    .tx_pend_i (tx_pend),
    .ack_i     (iack),
    .irq_o     (irq_o)
  );

  ep0_cs_hs u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_tok_i  (in_tok_i),
    .out_tok_i (out_tok_i),
    .zlp_i     (zlp_i),
    .cfg_i     (cfg),
    .hs_o      (hs_o)
  );

  always_comb begin
    reg_rdata_o                         = '0;
    reg_rdata_o[LEN_W-1:0]              = len;
    reg_rdata_o[DIR_BIT]                = cfg.dir;
    reg_rdata_o[CMPL_BIT]               = cfg.cmpl;
    reg_rdata_o[RDY_BIT]                = busy;
    reg_rdata_o[RESP_LO+1:RESP_LO]      = cfg.resp;
    reg_rdata_o[IACK_BIT]               = irq_o;
  end

  assign rdy_o = busy;
  assign len_o = len;

  // R12
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !setup_tok_i) |=> reg_rdata_o[RESP_LO+1:RESP_LO] == $past(reg_wdata_i[RESP_LO+1:RESP_LO]));
endmodule

// File: tb/sim_ep0_ctl_stage.sv
module sim_ep0_ctl_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_t = 0, in_t = 0, out_t = 0, zlp = 0;
  logic        rx_b = 0, rx_e = 0, f_rd = 0, f_wr = 0, r_wr = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  hs;
  logic        rdy, irq;
  logic [8:0]  len;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  int m_cmpl, m_dir, m_resp, m_len, m_busy, m_tx, m_irq, m_hs;

  always #4 clk = ~clk;

  ep0_ctl_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .setup_tok_i(setup_t), .in_tok_i(in_t),
    .out_tok_i(out_t), .zlp_i(zlp), .rx_byte_i(rx_b), .rx_end_i(rx_e),
    .fifo_rd_i(f_rd), .fifo_wr_i(f_wr), .reg_wr_i(r_wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .hs_o(hs), .rdy_o(rdy), .len_o(len), .irq_o(irq)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmpl = 0; m_dir = 0; m_resp = 0; m_len = 0;
      m_busy = 0; m_tx = 0; m_irq = 0; m_hs = 0;
    end else begin
      int rdok, wrok, bclr, iack;
      m_hs = 0;
      if (in_t || out_t) begin
        if (m_resp >= 2) m_hs = 8;
        else if ((m_dir == 0 && in_t) || (m_dir == 1 && out_t)) begin
          if (m_cmpl == 0 || m_resp == 0) m_hs = 2;
          else if (m_dir == 0)           m_hs = 4;
          else                           m_hs = zlp ? 1 : 2;
        end
      end
      rdok = (f_rd && !m_busy) ? 1 : 0;
      wrok = (f_wr && !m_busy) ? 1 : 0;
      bclr = (r_wr && wdata[14]) ? 1 : 0;
      iack = (r_wr && wdata[15]) ? 1 : 0;
      if (bclr && m_tx > 0) m_irq = 1;
      else if (iack)        m_irq = 0;
      if (bclr) m_tx = 0;
      else if (wrok && m_tx < 511) m_tx++;
      if (rx_b && !rdok) begin if (m_len < 511) m_len++; end
      else if (rdok && !rx_b) begin if (m_len > 0) m_len--; end
      if (rx_b) m_busy = 1; else if (rx_e) m_busy = 0;
      if (r_wr) begin m_cmpl = wdata[10]; m_dir = wdata[9]; m_resp = wdata[13:12]; end
      if (setup_t) m_cmpl = 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    int exp_rd;
    exp_rd = m_len | (m_dir << 9) | (m_cmpl << 10) | (m_busy << 11) |
             (m_resp << 12) | (m_irq << 15);
    chk("hs", hs, m_hs);
    chk("rdy", rdy, m_busy);
    chk("len", len, m_len);
    chk("irq", irq, m_irq);
    chk("rdata", rdata, exp_rd);
  endtask

  task automatic step();
    @(negedge clk);
    cmp_all();
    {setup_t, in_t, out_t, zlp, rx_b, rx_e, f_rd, f_wr, r_wr} = '0;
    wdata = '0;
  endtask

  task automatic wcfg(int cmpl, int dir, int resp);
    r_wr = 1; wdata = 16'(cmpl << 10 | dir << 9 | resp << 12); step();
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; step();
    chk("R1 hs at reset", hs, 0);
    chk("R1 rdata at reset", rdata, 0);

    cur_req = "R12"; wcfg(1, 0, 1);
    chk("R12 readback", rdata, 16'h1400);
    cur_req = "R2"; in_t = 1; step();
    chk("R2 zlp", hs, 4'b0100);
    cur_req = "R11"; step();
    chk("R11 pulse ends", hs, 0);
    cur_req = "R7"; out_t = 1; step();
    chk("R7 data stage OUT", hs, 0);

    cur_req = "R4"; wcfg(0, 0, 1); in_t = 1; step();
    chk("R4 cmpl0 nak", hs, 4'b0010);
    wcfg(1, 0, 0); in_t = 1; step();
    chk("R4 resp00 nak", hs, 4'b0010);

    cur_req = "R3"; wcfg(1, 1, 1); out_t = 1; zlp = 1; step();
    chk("R3 ack", hs, 4'b0001);
    out_t = 1; step();
    chk("R3 nonzero nak", hs, 4'b0010);
    cur_req = "R7"; in_t = 1; step();
    chk("R7 data stage IN", hs, 0);

    cur_req = "R5"; wcfg(1, 1, 2); in_t = 1; step();
    chk("R5 stall IN", hs, 4'b1000);
    wcfg(0, 0, 3); out_t = 1; step();
    chk("R5 stall OUT", hs, 4'b1000);

    cur_req = "R6"; wcfg(1, 0, 1); setup_t = 1; step();
    chk("R6 cleared", rdata[10], 0);
    in_t = 1; step();
    chk("R6 nak after setup", hs, 4'b0010);
    r_wr = 1; wdata = 16'h1400; setup_t = 1; step();
    chk("R6 setup beats write", rdata[10], 0);

    cur_req = "R8";
    repeat (5) begin rx_b = 1; step(); end
    rx_e = 1; step();
    chk("R8 count up", len, 5);
    repeat (3) begin f_rd = 1; step(); end
    chk("R8 count down", len, 2);
    repeat (4) begin f_rd = 1; step(); end
    chk("R8 floor", len, 0);
    repeat (515) begin rx_b = 1; step(); end
    chk("R8 ceiling", len, 511);
    cur_req = "R9";
    chk("R9 busy", rdy, 1);
    f_rd = 1; step();
    chk("R9 read ignored", len, 511);
    rx_e = 1; step();
    chk("R9 ready", rdy, 0);
    cur_req = "R8"; rx_b = 1; f_rd = 1; step();
    chk("R8 balanced", len, 511);
    rx_e = 1; step();

    cur_req = "R10"; r_wr = 1; wdata = 16'h4000; step();
    chk("R10 empty clear no irq", irq, 0);
    f_wr = 1; step(); f_wr = 1; step();
    r_wr = 1; wdata = 16'h4000; step();
    chk("R10 irq set", irq, 1);
    repeat (3) step();
    chk("R10 sticky", irq, 1);
    r_wr = 1; wdata = 16'h8000; step();
    chk("R10 ack", irq, 0);
    rx_b = 1; step(); f_wr = 1; step(); rx_e = 1; step();
    r_wr = 1; wdata = 16'h4000; step();
    chk("R10 write while busy ignored", irq, 0);

    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: setup_t = 1;
        1: in_t = 1;
        2: begin out_t = 1; zlp = 1'($urandom_range(0, 1)); end
        3: rx_b = 1;
        4: rx_e = 1;
        5: f_rd = 1;
        6: f_wr = 1;
        7: begin r_wr = 1; wdata = 16'($urandom) & 16'hbe00; end
        8: begin r_wr = 1; wdata = 16'($urandom) & 16'h7e00; end
        default: ;
      endcase
      if ($urandom_range(0, 3) == 0 && !f_wr) f_rd = 1;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule